// File: doc/BRIEF.md
# Parity-Split QPSK Carrier Mixer

The block turns a 16-bit data word into a stream of digital QPSK carrier samples. The word is de-interleaved by bit position. Even-indexed bits drive the in-phase branch and odd-indexed bits drive the quadrature branch, which gives eight symbols per word.

For each symbol, the in-phase bit selects a cosine carrier or its negation, and the quadrature bit selects a sine carrier or its negation. The carrier comes from an internal sixteen-point table folded from one quarter wave. A negation is a conditional inversion finished by a carry look-ahead adder. A second look-ahead adder sums the two branch products into a registered signed sample.

In use, a client presents a word and raises the enable. The block loads the word, plays the eight symbols one carrier period each, and pulses a completion flag. If the enable is still high in the completion cycle, the next word is taken at once. Dropping the enable freezes the waveform in place.

Top module: `qpsk_mix_mod`

## Requirements
- R1: A synchronous active-high reset forces the sample output to 0 and the completion flag to 0. The next word after reset starts again at symbol 0, phase 0, even when the reset lands in the middle of a word.
- R2: When the block is idle at a clock edge, the sample output becomes 0. If the enable is high at that edge, the data input is loaded. If the enable is low, nothing is loaded and the output stays 0.
- R3: Symbol k (k = 0 to 7, played in ascending order) takes its in-phase bit from data bit 2k and its quadrature bit from data bit 2k+1. Each symbol lasts 16 enabled cycles.
- R4: A bit value of 1 means +1 and a bit value of 0 means -1, so a branch product is the carrier sample or its two's-complement negation.
- R5: For phase p (0 to 15), the sine sample is round(127*sin(2*pi*p/16)) and the cosine sample is round(127*cos(2*pi*p/16)). Rounding is half away from zero. Phase starts at 0 after a load and advances by one on each enabled cycle.
- R6: Every enabled cycle of a running word registers the 9-bit signed sample I*cos(p) + Q*sin(p), with I and Q each +1 or -1. The sample is visible after the same edge that advances p, and it always lies within -254 to +254.
- R7: With the enable low while a word is running, phase, symbol and output all hold their values.
- R8: Changes on the data input while a word is running have no effect on the samples.
- R9: The completion flag is high for exactly one cycle, the one after the edge that registers symbol 7 phase 15. The output still holds that last sample during that cycle. If the enable is high in that cycle, the next word is loaded at the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable: starts a word when idle, advances the carrier when running |
| data_word | input | 16 | Data word, sampled only when idle |
| mod_sample | output | 9 | Signed modulated sample |
| word_done | output | 1 | One-cycle pulse after the final sample of a word |

## Verification
Two functions meet in one cycle: the completion pulse of one word and the load of the next. The completion cycle is both the last-sample hold and the load opportunity. The bench provokes this by keeping the enable high through the completion cycle with a new word already on the input. It then judges three things: the flag is high there with the final sample still held, the output drops to 0 at the load edge, and the whole next word matches from phase 0. Enable stalls at scattered points, and a reset in the middle of a word, test that the phase and symbol sequencing survives interruption.

// File: rtl/qpsk_mix_pkg.sv
package qpsk_mix_pkg;

    localparam int SAMP_W  = 8;
    localparam int OUT_W   = SAMP_W + 1;
    localparam int LUT_N   = 16;
    localparam int PHASE_W = $clog2(LUT_N);
    localparam int AMP     = (2 ** (SAMP_W - 1)) - 1;

    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} mix_state_t;

    typedef struct packed {
        logic i_bit;
        logic q_bit;
    } sym_pair_t;

    // quarter-wave sine in 16-bit fraction, scaled to AMP with rounding
    function automatic int quarter_amp(input int idx);
        int frac;
        case (idx)
            0:       frac = 0;
            1:       frac = 25080;
            2:       frac = 46341;
            3:       frac = 60547;
            default: frac = 65536;
        endcase
        return (AMP * frac + 32768) / 65536;
    endfunction

    function automatic logic signed [SAMP_W-1:0] sine_at(input logic [PHASE_W-1:0] ph);
        int idx;
        int v;
        idx = int'(ph[PHASE_W-3:0]);
        if (ph[PHASE_W-2]) idx = (LUT_N / 4) - idx;
        v = quarter_amp(idx);
        if (ph[PHASE_W-1]) v = -v;
        return v[SAMP_W-1:0];
    endfunction

endpackage

// File: rtl/qpsk_carrier_lut.sv
module qpsk_carrier_lut
    import qpsk_mix_pkg::*;
(
    input  logic [PHASE_W-1:0]       phase,
    output logic signed [SAMP_W-1:0] cos_s,
    output logic signed [SAMP_W-1:0] sin_s
);
    localparam logic [PHASE_W-1:0] QUARTER = PHASE_W'(LUT_N / 4);

    assign sin_s = sine_at(phase);
    assign cos_s = sine_at(phase + QUARTER);
endmodule

// File: rtl/qpsk_cla_add.sv
module qpsk_cla_add #(
    parameter int W = 9
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum
);
    logic [W-1:0] p;
    logic [W-1:0] g;
    logic [W-1:0] c;

    assign p = a ^ b;
    assign g = a & b;

    // flattened look-ahead: carry into bit i from every generate below it
    function automatic logic carry_into(input int i, input logic [W-1:0] pp,
                                        input logic [W-1:0] gg, input logic ci);
        logic acc;
        logic t;
        acc = 1'b0;
        for (int j = -1; j < i; j++) begin
            t = (j < 0) ? ci : gg[j];
            for (int k = j + 1; k < i; k++) t = t & pp[k];
            acc = acc | t;
        end
        return acc;
    endfunction

    for (genvar i = 0; i < W; i++) begin : g_carry
        assign c[i] = carry_into(i, p, g, cin);
    end

    assign sum = p ^ c;
endmodule

// File: rtl/qpsk_branch_mix.sv
module qpsk_branch_mix
    import qpsk_mix_pkg::*;
(
    input  logic signed [SAMP_W-1:0] carrier,
    input  logic                     bit_val,
    output logic signed [OUT_W-1:0]  prod
);
    logic [OUT_W-1:0] ext;
    logic [OUT_W-1:0] flip;
    logic [OUT_W-1:0] sum_u;

    assign ext  = {carrier[SAMP_W-1], carrier};
    assign flip = bit_val ? ext : ~ext;

    // bit 0 means -1: invert and add one through the look-ahead adder
    qpsk_cla_add #(.W(OUT_W)) u_neg (
        .a   (flip),
        .b   ('0),
        .cin (~bit_val),
        .sum (sum_u)
    );

    assign prod = signed'(sum_u);
endmodule

// File: rtl/qpsk_mix_mod.sv
module qpsk_mix_mod
    import qpsk_mix_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic [DATA_W-1:0]       data_word,
    output logic signed [OUT_W-1:0] mod_sample,
    output logic                    word_done
);
    localparam int NSYM  = DATA_W / 2;
    localparam int SYM_W = $clog2(NSYM);
    localparam logic [SYM_W-1:0]   SYM_LAST   = SYM_W'(NSYM - 1);
    localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(LUT_N - 1);

    mix_state_t             state_q;
    logic [PHASE_W-1:0]     phase_q;
    logic [SYM_W-1:0]       sym_q;
    logic [DATA_W-1:0]      word_q;
    logic signed [OUT_W-1:0] out_q;
    logic                   done_q;

    logic [NSYM-1:0]        even_bits;
    logic [NSYM-1:0]        odd_bits;
    sym_pair_t              cur_sym;
    logic signed [SAMP_W-1:0] cos_s;
    logic signed [SAMP_W-1:0] sin_s;
    logic signed [OUT_W-1:0]  prod_i;
    logic signed [OUT_W-1:0]  prod_q;
    logic [OUT_W-1:0]         mix_sum;

    for (genvar k = 0; k < NSYM; k++) begin : g_split
        assign even_bits[k] = word_q[2*k];
        assign odd_bits[k]  = word_q[2*k+1];
    end

    assign cur_sym.i_bit = even_bits[sym_q];
    assign cur_sym.q_bit = odd_bits[sym_q];

    qpsk_carrier_lut u_lut (
        .phase (phase_q),
        .cos_s (cos_s),
        .sin_s (sin_s)
    );

    qpsk_branch_mix u_mix_i (
        .carrier (cos_s),
        .bit_val (cur_sym.i_bit),
        .prod    (prod_i)
    );

    qpsk_branch_mix u_mix_q (
        .carrier (sin_s),
        .bit_val (cur_sym.q_bit),
        .prod    (prod_q)
    );

    qpsk_cla_add #(.W(OUT_W)) u_sum (
        .a   (prod_i),
        .b   (prod_q),
        .cin (1'b0),
        .sum (mix_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
            sym_q   <= '0;
            word_q  <= '0;
            out_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    out_q <= '0;
                    if (en) begin
                        word_q  <= data_word;
                        phase_q <= '0;
                        sym_q   <= '0;
                        state_q <= ST_RUN;
                    end
                end
                default: begin
                    if (en) begin
                        out_q   <= signed'(mix_sum);
                        phase_q <= phase_q + 1'b1;
                        if (phase_q == PHASE_LAST) begin
                            sym_q <= sym_q + 1'b1;
                            if (sym_q == SYM_LAST) begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                            end
                        end
                    end
                end
            endcase
        end
    end

    assign mod_sample = out_q;
    assign word_done  = done_q;
endmodule

// File: rtl/qpsk_mix_chk.sv
module qpsk_mix_chk
    import qpsk_mix_pkg::*;
#(
    parameter int SYM_W = 3
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    en,
    input logic signed [OUT_W-1:0] mod_sample,
    input logic                    word_done,
    input logic                    running,
    input logic [PHASE_W-1:0]      phase,
    input logic [SYM_W-1:0]        sym
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (mod_sample == '0) && !word_done);

    a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !running |=> (mod_sample == '0));

    a_r5_phase_step: assert property (@(posedge clk) disable iff (rst)
        (running && en) |=> (phase == PHASE_W'($past(phase) + 1'b1)));

    a_r6_range: assert property (@(posedge clk) disable iff (rst)
        (mod_sample <= 9'sd254) && (mod_sample >= -9'sd254));

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (running && !en) |=> $stable(mod_sample) && $stable(phase) && $stable(sym));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        word_done |=> !word_done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        word_done |-> !running);

    a_r9_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (running && en && (phase == '1) && (sym == '1)) |=> word_done);
endmodule

bind qpsk_mix_mod qpsk_mix_chk #(.SYM_W(SYM_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .mod_sample (mod_sample),
    .word_done  (word_done),
    .running    (state_q == qpsk_mix_pkg::ST_RUN),
    .phase      (phase_q),
    .sym        (sym_q)
);

// File: tb/qpsk_mix_mod_tb_top.sv
`timescale 1ns/1ps
module qpsk_mix_mod_tb_top;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en  = 1'b0;
    logic [15:0]       data_word = '0;
    logic signed [8:0] mod_sample;
    logic              word_done;

    int n_vec  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    qpsk_mix_mod dut_i (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .data_word  (data_word),
        .mod_sample (mod_sample),
        .word_done  (word_done)
    );

    function automatic int carrier(input int p, input bit use_cos);
        real v;
        v = 127.0 * (use_cos ? $cos(2.0 * 3.14159265358979 * p / 16.0)
                             : $sin(2.0 * 3.14159265358979 * p / 16.0));
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    function automatic int expect_sample(input logic [15:0] w, input int n);
        int k;
        int p;
        int ci;
        int sq;
        k  = n / 16;
        p  = n % 16;
        ci = w[2*k]   ? carrier(p, 1) : -carrier(p, 1);
        sq = w[2*k+1] ? carrier(p, 0) : -carrier(p, 0);
        return ci + sq;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    // plays one word; entered just after a negedge in an idle or done cycle
    task automatic run_word(input logic [15:0] w, input bit stall);
        int prev;
        data_word = w;
        en = 1'b1;
        @(negedge clk);
        check("R2 load edge output", int'(mod_sample), 0);
        check("R2 load edge done", int'(word_done), 0);
        prev = 0;
        for (int n = 0; n < 128; n++) begin
            data_word = ~w ^ 16'(n * 37);   // R8: ignored while running
            if (stall && (n % 5 == 2)) begin
                en = 1'b0;
                @(negedge clk);
                check($sformatf("R7 stall hold n=%0d", n), int'(mod_sample), prev);
                check("R7 stall done", int'(word_done), 0);
                en = 1'b1;
            end
            @(negedge clk);
            check($sformatf("R3 R4 R5 R6 R8 sample n=%0d", n), int'(mod_sample),
                  expect_sample(w, n));
            check($sformatf("R9 done flag n=%0d", n), int'(word_done), (n == 127) ? 1 : 0);
            prev = expect_sample(w, n);
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset output", int'(mod_sample), 0);
        check("R1 reset done", int'(word_done), 0);
        rst = 1'b0;
        en  = 1'b0;
        data_word = 16'hBEEF;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R2 idle without enable", int'(mod_sample), 0);
        end

        run_word(16'h0000, 0);
        run_word(16'hFFFF, 0);      // R9 back-to-back load in done cycle
        run_word(16'hAAAA, 0);
        run_word(16'h5555, 0);
        run_word(16'h1234, 1);
        run_word(16'hC3A5, 1);
        run_word(16'h9E27, 0);

        en = 1'b0;
        @(negedge clk);
        check("R2 idle output after word", int'(mod_sample), 0);
        check("R9 done single cycle", int'(word_done), 0);
        repeat (2) @(negedge clk);
        check("R2 idle stays zero", int'(mod_sample), 0);

        data_word = 16'h7F01;
        en = 1'b1;
        @(negedge clk);
        repeat (20) @(negedge clk);
        check("R1 mid-run before reset", int'(mod_sample), expect_sample(16'h7F01, 19));
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset output", int'(mod_sample), 0);
        check("R1 mid-run reset done", int'(word_done), 0);
        rst = 1'b0;
        en  = 1'b0;
        @(negedge clk);
        check("R1 after reset idle", int'(mod_sample), 0);
        run_word(16'h7F01, 1);      // R1 restart from symbol 0 phase 0
        run_word(16'h0F0F, 0);

        en = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule